// File: doc/BRIEF.md
# Board Interrupt Level Encoder

This block collects thirteen level-sensitive interrupt requests from peripherals on a board: the four PCI INTx lines, compact-flash IDE and card-detect, a display controller, keypad, two real-time-clock events, an SD slot, an external line and a touch panel. It keeps a live status word in which each request owns one fixed bit. It ANDs that word with an enable mask that software can write. From the sources that remain, it picks the one with the smallest fixed priority number. The block sends that number to the CPU as a 4-bit encoded level, inverted so that an idle board drives 0.

Software reaches the block through a small 16-bit register window of 64 bytes. The window holds the enable mask, a power-off control word, a general output-port word and a constant version word. The power-off and output-port words also drive output pins, so other board logic can use them.

Top module: `irq_level_enc`

## Requirements
- R1: Each source index on `irq_req_i` has a fixed status bit and a fixed priority, given as index:(bit, priority). The mapping is 0:(9,1), 1:(8,2), 2:(14,9), 3:(13,10), 4:(12,3), 5:(11,0), 6:(10,4), 7:(6,5), 8:(5,6), 9:(4,7), 10:(7,8), 11:(0,11), 12:(15,12).
- R2: A source's status bit is 1 while its request input is high and 0 while it is low. Raising an input, or lowering it again, changes the level output as R3 to R5 dictate.
- R3: A source competes only when both its status bit and the mask bit at the same position are 1. A source with its mask bit at 0 has no effect on the level output.
- R4: Among the competing sources, the smallest priority number is selected. With no competing source, the selected value is 15.
- R5: `cpu_level_o` equals the selected value XOR 15. An idle board gives 0, and priority 0 (source 5) gives 15.
- R6: `cpu_level_o` is registered. It takes its new value on the first rising edge after a request input changes or after the clock edge that writes the mask, and not earlier.
- R7: A synchronous active-high `rst` clears the status, mask, power-off and output-port words, and also the read data. This makes `cpu_level_o` 0.
- R8: Offset 0x00 is the enable mask. Offset 0x30 is the power-off word, which also drives `pwr_ctl_o`. Offset 0x36 is the output-port word, which also drives `port_out_o`. All three are readable and writable over all 16 bits.
- R9: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R10: A read of any other offset returns 0, and a write to any other offset leaves all registers unchanged.
- R11: Read data appears on `bus_rdata_o` in the cycle after the one-cycle read strobe. In cycles that follow no read, `bus_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_req_i | input | 13 | Level interrupt requests, by source index |
| bus_rd_i | input | 1 | One-cycle read strobe |
| bus_wr_i | input | 1 | One-cycle write strobe |
| bus_addr_i | input | 6 | Byte offset within the window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, registered |
| cpu_level_o | output | 4 | Encoded interrupt level to the CPU |
| pwr_ctl_o | output | 16 | Power-off register contents |
| port_out_o | output | 16 | Output-port register contents |

## Verification
The hardest cases to reach are those where the winner depends on the priority order and not on the bit order. One example is PCI INTD at bit 11 beating IDE at bit 9 while touch, at the top bit, loses to everything. Another is a masked high-priority source sitting under an enabled low-priority one. To cover these, the bench runs every ordered pair of active sources under a full mask. It then runs a long pseudo-random walk over request and mask words, and each time compares the output with a priority search that the bench computes on its own. The latency of mask writes is checked separately: the bench samples the level just before and just after the writing edge.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

  localparam int NUM_SRC = 13;
  localparam int DATA_W  = 16;
  localparam int LVL_W   = 4;
  localparam int IDLE_SEL = (1 << LVL_W) - 1;

  // status bit owned by each source index
  function automatic int src_bit(int idx);
    case (idx)
      0: return 9;   1: return 8;   2: return 14;  3: return 13;
      4: return 12;  5: return 11;  6: return 10;  7: return 6;
      8: return 5;   9: return 4;   10: return 7;  11: return 0;
      default: return 15;
    endcase
  endfunction

  // priority number of each source index (smaller wins)
  function automatic int src_prio(int idx);
    case (idx)
      0: return 1;   1: return 2;   2: return 9;   3: return 10;
      4: return 3;   5: return 0;   6: return 4;   7: return 5;
      8: return 6;   9: return 7;   10: return 8;  11: return 11;
      default: return 12;
    endcase
  endfunction

  // spread request lines onto their status positions
  function automatic logic [DATA_W-1:0] place_requests(logic [NUM_SRC-1:0] req);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_SRC; i++) w[src_bit(i)] = req[i];
    return w;
  endfunction

  // smallest priority among pending enabled sources, idle value when none
  function automatic logic [LVL_W-1:0] pick_priority(logic [DATA_W-1:0] pend);
    int best;
    best = IDLE_SEL;
    for (int i = 0; i < NUM_SRC; i++)
      if (pend[src_bit(i)] && src_prio(i) < best) best = src_prio(i);
    return LVL_W'(best);
  endfunction

  function automatic logic [LVL_W-1:0] encode_level(logic [LVL_W-1:0] sel);
    return sel ^ LVL_W'(IDLE_SEL);
  endfunction

endpackage

// File: rtl/irq_status_track.sv
module irq_status_track
  import irq_level_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] req_i,
  output logic [DATA_W-1:0] word_next_o,
  output logic [DATA_W-1:0] status_o
);

  logic [DATA_W-1:0] status_q;

  always_comb word_next_o = place_requests(req_i);

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= word_next_o;
  end

  assign status_o = status_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_follow
    localparam int BITPOS = src_bit(g);
    // R2
    status_set_chk: assert property (@(posedge clk) disable iff (rst)
      req_i[g] |=> status_q[BITPOS]);
    // R2
    status_clr_chk: assert property (@(posedge clk) disable iff (rst)
      !req_i[g] |=> !status_q[BITPOS]);
  end

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
  import irq_level_pkg::*;
(
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] pend_o,
  output logic [LVL_W-1:0]  sel_o,
  output logic [LVL_W-1:0]  level_o
);

  always_comb begin
    pend_o  = status_i & mask_i;
    sel_o   = pick_priority(pend_o);
    level_o = encode_level(sel_o);
  end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_level_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [DATA_W-1:0] VERSION_ID = 16'h0010,
  parameter logic [ADDR_W-1:0] OFS_MASK = 6'h00,
  parameter logic [ADDR_W-1:0] OFS_PWR  = 6'h30,
  parameter logic [ADDR_W-1:0] OFS_VER  = 6'h32,
  parameter logic [ADDR_W-1:0] OFS_PORT = 6'h36
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] mask_next_o,
  output logic [DATA_W-1:0] pwr_o,
  output logic [DATA_W-1:0] port_o
);

  logic [DATA_W-1:0] mask_q, pwr_q, port_q, rdata_q, rd_mux;
  logic mask_wr_w, pwr_wr_w, port_wr_w, unmapped_w;

  assign mask_wr_w  = wr_i && (addr_i == OFS_MASK);
  assign pwr_wr_w   = wr_i && (addr_i == OFS_PWR);
  assign port_wr_w  = wr_i && (addr_i == OFS_PORT);
  assign unmapped_w = (addr_i != OFS_MASK) && (addr_i != OFS_PWR) &&
                      (addr_i != OFS_VER)  && (addr_i != OFS_PORT);

  always_comb mask_next_o = mask_wr_w ? wdata_i : mask_q;

  always_comb begin
    unique case (1'b1)
      addr_i == OFS_MASK: rd_mux = mask_q;
      addr_i == OFS_PWR:  rd_mux = pwr_q;
      addr_i == OFS_VER:  rd_mux = VERSION_ID;
      addr_i == OFS_PORT: rd_mux = port_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      pwr_q   <= '0;
      port_q  <= '0;
      rdata_q <= '0;
    end else begin
      mask_q <= mask_next_o;
      if (pwr_wr_w)  pwr_q  <= wdata_i;
      if (port_wr_w) port_q <= wdata_i;
      rdata_q <= rd_i ? rd_mux : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign pwr_o   = pwr_q;
  assign port_o  = port_q;

  // R9
  version_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == OFS_VER) |=> rdata_q == VERSION_ID);
  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && unmapped_w) |=> rdata_q == '0);
  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && (unmapped_w || addr_i == OFS_VER)) |=>
      ($stable(mask_q) && $stable(pwr_q) && $stable(port_q)));
  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> rdata_q == '0);

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_level_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [DATA_W-1:0] VERSION_ID = 16'h0010
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [LVL_W-1:0]   cpu_level_o,
  output logic [DATA_W-1:0]  pwr_ctl_o,
  output logic [DATA_W-1:0]  port_out_o
);

  localparam int TOP_SRC_BIT = src_bit(5);

  logic [DATA_W-1:0] word_next_w, status_w, mask_w, mask_next_w;
  logic [DATA_W-1:0] pend_next_w, pend_now_w;
  logic [LVL_W-1:0]  sel_next_w, level_next_w, level_q;

  irq_status_track u_track (
    .clk(clk), .rst(rst), .req_i(irq_req_i),
    .word_next_o(word_next_w), .status_o(status_w)
  );

  irq_regfile #(.ADDR_W(ADDR_W), .VERSION_ID(VERSION_ID)) u_regs (
    .clk(clk), .rst(rst), .rd_i(bus_rd_i), .wr_i(bus_wr_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .mask_o(mask_w), .mask_next_o(mask_next_w),
    .pwr_o(pwr_ctl_o), .port_o(port_out_o)
  );

  // resolve on next-cycle state so the output lags inputs by one edge
  irq_prio_resolve u_resolve (
    .status_i(word_next_w), .mask_i(mask_next_w),
    .pend_o(pend_next_w), .sel_o(sel_next_w), .level_o(level_next_w)
  );

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level_next_w;
  end

  assign cpu_level_o = level_q;
  assign pend_now_w  = status_w & mask_w;

  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_now_w == '0) |-> (level_q == '0));
  // R4
  busy_level_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_now_w != '0) |-> (level_q != '0));
  // R5
  top_level_chk: assert property (@(posedge clk) disable iff (rst)
    pend_now_w[TOP_SRC_BIT] |-> (level_q == 4'hF));
  // R7
  reset_level_chk: assert property (@(posedge clk)
    rst |=> (level_q == '0 && mask_w == '0 && status_w == '0));

endmodule

// File: tb/irq_level_enc_bench.sv
module irq_level_enc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] req = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, pwr, port;
  logic [3:0]  level;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_enc u_irq_level_enc (
    .clk(clk), .rst(rst), .irq_req_i(req), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cpu_level_o(level), .pwr_ctl_o(pwr), .port_out_o(port)
  );

  // R1 table, restated
  function automatic int bit_of(int s);
    int t[NS] = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};
    return t[s];
  endfunction
  function automatic int prio_of(int s);
    int t[NS] = '{1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12};
    return t[s];
  endfunction
  function automatic logic [3:0] expect_level(logic [12:0] r, logic [15:0] m);
    int win;
    win = 15;
    for (int s = 0; s < NS; s++)
      if (r[s] && m[bit_of(s)] && prio_of(s) < win) win = prio_of(s);
    return 4'(15 - win);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [15:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_req(logic [12:0] r);
    @(negedge clk); req = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] lf;
    logic [15:0] m;
    logic [12:0] r;

    req = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7 reset state (requests high but mask cleared)
    check("R7 level after reset", 16'(level), 16'h0);
    check("R7 power word", pwr, 16'h0);
    check("R7 port word", port, 16'h0);
    check("R11 idle rdata", rdata, 16'h0);
    bus_read(6'h00, v); check("R7 mask reads zero", v, 16'h0);
    req = '0;

    // R8 register access
    bus_write(6'h00, 16'hA5C3); bus_read(6'h00, v); check("R8 mask rw", v, 16'hA5C3);
    bus_write(6'h30, 16'h1234); bus_read(6'h30, v); check("R8 power rw", v, 16'h1234);
    check("R8 power pins", pwr, 16'h1234);
    bus_write(6'h36, 16'hBEEF); bus_read(6'h36, v); check("R8 port rw", v, 16'hBEEF);
    check("R8 port pins", port, 16'hBEEF);
    // R11 rdata returns to zero after a read
    @(negedge clk); check("R11 rdata cleared", rdata, 16'h0);

    // R9 version
    bus_read(6'h32, v); check("R9 version", v, 16'h0010);
    bus_write(6'h32, 16'hFFFF); bus_read(6'h32, v); check("R9 version after write", v, 16'h0010);
    bus_read(6'h00, v); check("R9 mask untouched", v, 16'hA5C3);

    // R10 unmapped offsets
    for (int a = 0; a < 64; a++) begin
      if (a != 6'h00 && a != 6'h30 && a != 6'h32 && a != 6'h36) begin
        bus_write(6'(a), 16'h5A5A);
        bus_read(6'(a), v); check("R10 unmapped read", v, 16'h0);
      end
    end
    bus_read(6'h00, v); check("R10 mask kept", v, 16'hA5C3);
    check("R10 power kept", pwr, 16'h1234);
    check("R10 port kept", port, 16'hBEEF);

    // R1 R4 R5: every ordered pair under full mask
    bus_write(6'h00, 16'hFFFF);
    for (int a = 0; a < NS; a++) begin
      for (int b = 0; b < NS; b++) begin
        r = '0; r[a] = 1'b1; r[b] = 1'b1;
        set_req(r);
        check("R4 pair winner", 16'(level), 16'(expect_level(r, 16'hFFFF)));
      end
    end
    // R5 corners
    set_req(13'h0); check("R5 idle level", 16'(level), 16'h0);
    set_req(13'h0020); check("R5 priority zero", 16'(level), 16'hF);
    set_req(13'h1000); check("R5 lowest priority", 16'(level), 16'h3);

    // R3 each source alone with only its own mask bit cleared
    for (int s = 0; s < NS; s++) begin
      m = 16'hFFFF; m[bit_of(s)] = 1'b0;
      bus_write(6'h00, m);
      r = '0; r[s] = 1'b1;
      set_req(r);
      check("R3 masked source ignored", 16'(level), 16'h0);
    end

    // R2 release sources one by one, winner shifts each time
    bus_write(6'h00, 16'hFFFF);
    r = '1; set_req(r);
    for (int p = 0; p < NS; p++) begin
      for (int s = 0; s < NS; s++) if (prio_of(s) == p) r[s] = 1'b0;
      set_req(r);
      check("R2 release follows", 16'(level), 16'(expect_level(r, 16'hFFFF)));
    end

    // R6 latency: input change
    @(negedge clk); req = 13'h0001;
    #1; check("R6 no change before edge", 16'(level), 16'h0);
    @(negedge clk); check("R6 change after one edge", 16'(level), 16'hE);
    // R6 latency: mask write
    @(negedge clk); wr = 1'b1; addr = 6'h00; wdata = 16'h0000;
    #1; check("R6 mask write before edge", 16'(level), 16'hE);
    @(negedge clk); wr = 1'b0;
    check("R6 mask write after edge", 16'(level), 16'h0);

    // R3 R4 R5 pseudo-random walk over requests and mask
    lf = 32'h1ACE_B00C;
    for (int k = 0; k < 400; k++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      m = lf[15:0];
      r = lf[28:16];
      bus_write(6'h00, m);
      set_req(r);
      check("R4 random mix", 16'(level), 16'(expect_level(r, m)));
    end

    // R7 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R7 level cleared", 16'(level), 16'h0);
    check("R7 power cleared", pwr, 16'h0);
    check("R7 port cleared", port, 16'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule